// File: doc/BRIEF.md
# Saturating Adder with Averaging

This block adds two W-bit operands. The result either wraps or is clamped to the extreme value the selected number format can hold. A second mode halves the sum so that the block can average two samples. The operands can be treated as unsigned or as two's complement. The block suits signal-processing and media kernels, where a result that is close to right and clamped is better than a trap. The block never raises an exception, so its result always arrives after the same latency.

Each cycle the block samples the operands and the three mode controls on the rising clock edge. One edge later it presents the result, together with two range flags that describe the exact sum before any clamping. In averaging mode the block first forms the W-bit sum, wrapped or clamped as the saturate control selects, and then shifts that sum right by one place.

Top module: `sat_avg_adder`

## Requirements
- R1: While rst_n is low, result, ovf and unf are all 0.
- R2: Outputs reflect the inputs sampled at the previous rising edge (latency of one cycle), and a new result is produced every cycle with no stall.
- R3: With sat_en=0 and avg_en=0, result equals (opa + opb) modulo 2^W in both signed and unsigned modes.
- R4: Unsigned mode (is_signed=0): when the exact sum exceeds 2^W-1, ovf=1, and with sat_en=1 and avg_en=0 the result is all ones.
- R5: Signed mode (is_signed=1): two non-negative operands whose wrapped sum has MSB 1 give ovf=1, and with sat_en=1 the clamped sum is 0 followed by W-1 ones. Two negative operands whose wrapped sum has MSB 0 give unf=1, and with sat_en=1 the clamped sum is 1 followed by W-1 zeros.
- R6: ovf and unf describe the exact, unclamped sum regardless of sat_en and avg_en. They are never both 1, and unf is always 0 in unsigned mode.
- R7: With avg_en=1, result is the W-bit sum (wrapped if sat_en=0, clamped if sat_en=1) shifted right by one bit. The shift is logical in unsigned mode (result MSB 0) and arithmetic in signed mode (MSB copied).
- R8: For unsigned operands 0x7000 and 0x9000 (exact average 0x8000), the result is 0x0000 when wrapping, 0xFFFF when saturating, 0x0000 when averaging with wrap and 0x7FFF when averaging with saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| sat_en | input | 1 | 1: clamp out-of-range sums, 0: wrap |
| avg_en | input | 1 | 1: output half of the W-bit sum |
| result | output | W | Registered result |
| ovf | output | 1 | Registered flag: exact sum above the format's maximum |
| unf | output | 1 | Registered flag: exact sum below the format's minimum |

## Verification
The clocked assertions assume that every input is driven to a known 0 or 1 at each rising edge once reset is released, because they relate each output to the controls of the previous cycle. The bench changes its inputs only just after a rising edge, so it never presents an X. Its operand mix weights the extremes: all ones, the sign boundary values and zero are chosen often, so the carry-out, positive-overflow and negative-underflow paths all fire in every mode combination.

// File: rtl/sat_avg_pkg.sv
package sat_avg_pkg;
  typedef struct packed {
    logic over;
    logic under;
  } range_flags_t;
endpackage

// File: rtl/sa_sum_core.sv
module sa_sum_core #(
  parameter int W = 16
) (
  input  logic [W-1:0]               a,
  input  logic [W-1:0]               b,
  input  logic                       is_signed,
  output logic [W-1:0]               sum_wrap,
  output logic                       carry_out,
  output sat_avg_pkg::range_flags_t  flags
);
  localparam int EW = W + 1;

  function automatic logic [EW-1:0] add_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic sat_avg_pkg::range_flags_t classify(
    input logic sg, input logic c, input logic xs, input logic ys, input logic rs);
    sat_avg_pkg::range_flags_t f;
    if (sg) begin
      f.over  = ~xs & ~ys & rs;
      f.under = xs & ys & ~rs;
    end else begin
      f.over  = c;
      f.under = 1'b0;
    end
    return f;
  endfunction

  logic [EW-1:0] ext;

  always_comb begin
    ext       = add_ext(a, b);
    sum_wrap  = ext[W-1:0];
    carry_out = ext[W];
    flags     = classify(is_signed, ext[W], a[W-1], b[W-1], ext[W-1]);
  end
endmodule

// File: rtl/sa_clamp.sv
module sa_clamp #(
  parameter int W = 16
) (
  input  logic [W-1:0]               sum_wrap,
  input  sat_avg_pkg::range_flags_t  flags,
  input  logic                       is_signed,
  input  logic                       sat_en,
  output logic [W-1:0]               sum_fit
);
  localparam logic [W-1:0] U_MAX = {W{1'b1}};
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    sum_fit = sum_wrap;
    if (sat_en) begin
      if (flags.over)       sum_fit = is_signed ? S_MAX : U_MAX;
      else if (flags.under) sum_fit = S_MIN;
    end
  end
endmodule

// File: rtl/sa_halver.sv
module sa_halver #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         is_signed,
  input  logic         avg_en,
  output logic [W-1:0] dout
);
  function automatic logic [W-1:0] half(input logic [W-1:0] v, input logic sg);
    return {sg & v[W-1], v[W-1:1]};
  endfunction

  always_comb dout = avg_en ? half(din, is_signed) : din;
endmodule

// File: rtl/sat_avg_adder.sv
module sat_avg_adder #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         is_signed,
  input  logic         sat_en,
  input  logic         avg_en,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         unf
);
  localparam logic [W-1:0] U_MAX = {W{1'b1}};
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]              sum_wrap;
  logic                      carry_out;
  sat_avg_pkg::range_flags_t flags;
  logic [W-1:0]              sum_fit;
  logic [W-1:0]              next_res;

  sa_sum_core #(.W(W)) u_sum (
    .a(opa), .b(opb), .is_signed(is_signed),
    .sum_wrap(sum_wrap), .carry_out(carry_out), .flags(flags)
  );

  sa_clamp #(.W(W)) u_clamp (
    .sum_wrap(sum_wrap), .flags(flags), .is_signed(is_signed),
    .sat_en(sat_en), .sum_fit(sum_fit)
  );

  sa_halver #(.W(W)) u_half (
    .din(sum_fit), .is_signed(is_signed), .avg_en(avg_en), .dout(next_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      result <= next_res;
      ovf    <= flags.over;
      unf    <= flags.under;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (result == '0 && !ovf && !unf)); // R1

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf)); // R6

  AST_UNSIGNED_NO_UNF: assert property (@(posedge clk) disable iff (!rst_n)
    !is_signed |=> !unf); // R6

  AST_WRAP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_en && !avg_en) |=> result == $past(sum_wrap)); // R3

  AST_UNSIGNED_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_signed && sat_en && !avg_en && carry_out) |=> (result == U_MAX && ovf)); // R4

  AST_SIGNED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (is_signed && sat_en && !avg_en && !opa[W-1] && !opb[W-1] && sum_wrap[W-1])
      |=> (result == S_MAX && ovf)); // R5

  AST_SIGNED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_signed && sat_en && !avg_en && opa[W-1] && opb[W-1] && !sum_wrap[W-1])
      |=> (result == S_MIN && unf)); // R5

  AST_AVG_LOGICAL: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_en && !is_signed) |=> !result[W-1]); // R7

  AST_AVG_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_en && is_signed) |=> result[W-1] == result[W-2]); // R7
endmodule

// File: tb/tb_sat_avg_adder.sv
module tb_sat_avg_adder;
  localparam int W = 16;
  localparam longint UMAX = (64'sd1 <<< W) - 1;
  localparam longint SMAX = (64'sd1 <<< (W-1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic is_signed = 1'b0, sat_en = 1'b0, avg_en = 1'b0;
  logic [W-1:0] result;
  logic ovf, unf;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { longint res; bit o; bit u; string tag; } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  sat_avg_adder #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .is_signed(is_signed),
    .sat_en(sat_en), .avg_en(avg_en), .result(result), .ovf(ovf), .unf(unf)
  );

  function automatic longint as_num(logic [W-1:0] v, bit sg);
    longint n = longint'(v);
    if (sg && n > SMAX) n = n - (UMAX + 1);
    return n;
  endfunction

  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b,
                                 bit sg, bit sat, bit avg, string tag);
    exp_t e;
    longint s = as_num(a, sg) + as_num(b, sg);
    longint hi = sg ? SMAX : UMAX;
    longint lo = sg ? SMIN : 0;
    longint v;
    e.o = s > hi;
    e.u = s < lo;
    if (sat) v = e.o ? hi : (e.u ? lo : s);
    else     v = as_num(logic'(s[W-1:0]) ? W'(s) : W'(s), sg);
    v = as_num(W'(v), sg);
    if (avg) v = sg ? (v >>> 1) : (v / 2);
    e.res = v & UMAX;
    e.tag = tag;
    return e;
  endfunction

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, bit sg, bit sat, bit avg, string tag);
    exp_t e;
    opa = a; opb = b; is_signed = sg; sat_en = sat; avg_en = avg;
    expq.push_back(model(a, b, sg, sat, avg, tag));
    @(posedge clk); #1;
    e = expq.pop_front();
    check({e.tag, " result"}, longint'(result), e.res);
    check({e.tag, " ovf"}, longint'(ovf), longint'(e.o));
    check({e.tag, " unf"}, longint'(unf), longint'(e.u));
    check("R6 flags exclusive", longint'(ovf & unf), 0);
  endtask

  function automatic logic [W-1:0] pick();
    case ($urandom % 6)
      0: return '0;
      1: return '1;
      2: return {1'b0, {(W-1){1'b1}}};
      3: return {1'b1, {(W-1){1'b0}}};
      default: return W'($urandom);
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 result", longint'(result), 0);
    check("R1 ovf", longint'(ovf), 0);
    check("R1 unf", longint'(unf), 0);
    rst_n = 1'b1;

    apply(16'h7000, 16'h9000, 0, 0, 0, "R8 wrap");
    apply(16'h7000, 16'h9000, 0, 1, 0, "R8 sat");
    apply(16'h7000, 16'h9000, 0, 0, 1, "R8 avg wrap");
    apply(16'h7000, 16'h9000, 0, 1, 1, "R8 avg sat");
    apply(16'h1234, 16'h0101, 0, 0, 0, "R3 plain");
    apply(16'hFFFF, 16'h0001, 1, 0, 0, "R3 signed wrap");
    apply(16'hFFFF, 16'hFFFF, 0, 1, 0, "R4 carry clamp");
    apply(16'h7FFF, 16'h0001, 1, 1, 0, "R5 high clamp");
    apply(16'h8000, 16'hFFFF, 1, 1, 0, "R5 low clamp");
    apply(16'h8000, 16'h8000, 1, 0, 0, "R6 unf on wrap");
    apply(16'h7FFF, 16'h0001, 1, 0, 1, "R7 signed avg wrap");
    apply(16'h8000, 16'h8000, 1, 1, 1, "R7 signed avg sat");
    apply(16'hFFF0, 16'h0004, 1, 0, 1, "R7 negative avg");
    apply(16'hFFFF, 16'hFFFF, 0, 0, 1, "R7 unsigned avg");

    for (int i = 0; i < 400; i++)
      apply(pick(), pick(), 1'($urandom), 1'($urandom), 1'($urandom), "R2 R3 R7 mixed");

    rst_n = 1'b0;
    opa = 16'hFFFF; opb = 16'hFFFF; sat_en = 1'b1;
    @(posedge clk); #1;
    check("R1 mid reset result", longint'(result), 0);
    check("R1 mid reset ovf", longint'(ovf), 0);
    rst_n = 1'b1;
    apply(16'h0003, 16'h0004, 0, 0, 0, "R2 after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(20000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule